// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block decides, at each instruction boundary of a small 8-bit core, whether to enter an interrupt handler, return from one, or do neither. Maskable requests from several lines and a single non-maskable request are captured in pending latches. When a request is accepted, the block pushes the current program counter onto a shallow hardware stack. It then offers the handler's fixed vector as the next PC and moves the core into the matching mode.

Each of the three modes (normal, interrupt, non-maskable) owns a private carry/zero flag pair. The pair that is read and written always follows the current mode, so handlers never save or restore flags through memory. On a return strobe, the block pops the saved PC and re-enters the interrupted mode, which brings that mode's flags back into view. The pending latches are visible on an output, so that handler software can poll for the source.

Top module: `irq_seq`

## Requirements
- R1: After reset the mode is normal (00), `pc_load` is low, all six flag bits read 0 and no request is pending.
- R2: The mode is encoded normal=00, interrupt=01, non-maskable=10. `c_out`/`z_out` show the flag pair owned by the current mode, and `flag_we` writes only that pair.
- R3: A pulse on a request input sets its pending latch, which is visible on `irq_pend` (bit i is line i) the next cycle. Nothing is accepted and `pc_load` stays low while `boundary` is low.
- R4: A maskable request is accepted only in normal mode with `gie` high. The lowest-numbered pending line wins, `pc_next` = MVEC_BASE + 2*line, that line's latch clears, and the mode becomes 01.
- R5: A pending non-maskable request is accepted in normal or interrupt mode whatever `gie` is, and it beats maskable requests. `pc_next` = NMI_VEC and the mode becomes 10.
- R6: On every acceptance, `pc_in` is pushed. A later return presents the most recently pushed value on `pc_next` with `pc_load` high.
- R7: A return from mode 01 goes to mode 00. A return from mode 10 goes to the mode that was active when that non-maskable request was accepted.
- R8: A return strobe in normal mode is ignored: there is no pop and the mode is unchanged. In any other mode, a return at a boundary takes precedence over pending requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_set | input | NVEC | Maskable request pulses, one per line |
| nmi_set | input | 1 | Non-maskable request pulse |
| gie | input | 1 | Global enable for maskable requests |
| boundary | input | 1 | High in the last cycle of an instruction |
| reti | input | 1 | Return-from-interrupt strobe, valid with boundary |
| pc_in | input | PC_W | Address of the next instruction in sequence |
| flag_we | input | 1 | Write the active flag pair |
| c_in | input | 1 | Carry value to write |
| z_in | input | 1 | Zero value to write |
| pc_load | output | 1 | Core must take pc_next this boundary |
| pc_next | output | PC_W | Vector or popped return address |
| mode | output | 2 | Current mode |
| c_out | output | 1 | Active carry flag |
| z_out | output | 1 | Active zero flag |
| irq_pend | output | NVEC | Pending maskable latches |

## Verification
The bench nests a non-maskable entry inside a maskable handler and unwinds it. A design that restored the wrong mode, popped a stale address or shared one flag pair between modes would show a changed flag or a wrong `pc_next` on the way back. It drives two maskable lines at once, to catch a wrong priority or a latch left set after acceptance. It also drives a non-maskable request together with a maskable one. In handler mode it raises a return together with a pending request, to catch re-entry before the pop. In normal mode it raises a return alone, to catch a spurious pop.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int PC_W = 12,
  parameter int NVEC = 4,
  parameter int DEPTH = 6,
  parameter logic [11:0] MVEC_BASE = 12'hFF0,
  parameter logic [11:0] NMI_VEC = 12'hFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irq_set,
  input  logic            nmi_set,
  input  logic            gie,
  input  logic            boundary,
  input  logic            reti,
  input  logic [PC_W-1:0] pc_in,
  input  logic            flag_we,
  input  logic            c_in,
  input  logic            z_in,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_next,
  output logic [1:0]      mode,
  output logic            c_out,
  output logic            z_out,
  output logic [NVEC-1:0] irq_pend
);
  localparam int IW = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] M_NORM = 2'b00, M_INT = 2'b01, M_NMI = 2'b10;

  logic            nmi_pend;
  logic [1:0]      saved_mode;
  logic [PC_W-1:0] stk [DEPTH];
  logic [CW-1:0]   cnt;
  logic [PC_W-1:0] last_pop, pop_val;
  logic [2:0]      cbank, zbank;
  logic [IW-1:0]   sel;
  logic [NVEC-1:0] clr;
  logic            do_ret, do_nmi, do_irq, push;

  always_comb begin
    sel = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (irq_pend[i]) sel = IW'(i);
  end

  assign do_ret  = boundary && reti && mode != M_NORM;
  assign do_nmi  = boundary && !do_ret && nmi_pend && mode != M_NMI;
  assign do_irq  = boundary && !do_ret && !do_nmi && mode == M_NORM && gie && |irq_pend;
  assign push    = do_nmi || do_irq;
  assign pop_val = (cnt == '0) ? last_pop : stk[0];
  assign clr     = do_irq ? (NVEC'(1) << sel) : '0;

  assign pc_load = do_ret || push;
  assign pc_next = do_ret ? pop_val :
                   do_nmi ? NMI_VEC[PC_W-1:0] :
                   MVEC_BASE[PC_W-1:0] + PC_W'({sel, 1'b0});

  assign c_out = cbank[mode];
  assign z_out = zbank[mode];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pend   <= '0;
      nmi_pend   <= 1'b0;
      mode       <= M_NORM;
      saved_mode <= M_NORM;
      cbank      <= '0;
      zbank      <= '0;
    end else begin
      irq_pend <= (irq_pend & ~clr) | irq_set;
      nmi_pend <= (nmi_pend && !do_nmi) || nmi_set;
      if (flag_we) begin
        cbank[mode] <= c_in;
        zbank[mode] <= z_in;
      end
      if (do_ret)
        mode <= (mode == M_NMI) ? saved_mode : M_NORM;
      else if (do_nmi) begin
        saved_mode <= mode;
        mode       <= M_NMI;
      end else if (do_irq)
        mode <= M_INT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      last_pop <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      stk[0] <= pc_in;
      for (int i = 1; i < DEPTH; i++) stk[i] <= stk[i-1];
      if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (do_ret) begin
      last_pop <= pop_val;
      for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'b11);
  a_r3_no_load_off_boundary: assert property (@(posedge clk) disable iff (!rst_n) !boundary |-> !pc_load);
  a_r4_int_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && !gie && !nmi_pend) |=> mode == M_NORM);
  a_r5_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !reti && nmi_pend && mode != M_NMI) |=> mode == M_NMI);
  a_r7_int_return: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && reti && mode == M_INT) |=> mode == M_NORM);
  a_r8_norm_reti_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && reti && mode == M_NORM && !nmi_pend && !(gie && |irq_pend)) |=> $stable(cnt) && mode == M_NORM);
  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
endmodule

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] irq_set = '0;
  logic nmi_set = 0, gie = 0, boundary = 0, reti = 0, flag_we = 0, c_in = 0, z_in = 0;
  logic [11:0] pc_in = '0;
  logic pc_load, c_out, z_out;
  logic [11:0] pc_next;
  logic [1:0] mode;
  logic [3:0] irq_pend;
  int errs = 0, checks = 0;

  irq_seq dut_i (.clk, .rst_n, .irq_set, .nmi_set, .gie, .boundary, .reti, .pc_in,
                 .flag_we, .c_in, .z_in, .pc_load, .pc_next, .mode, .c_out, .z_out, .irq_pend);

  always #2 clk = ~clk;

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic set_flags(logic c, logic z);
    flag_we = 1; c_in = c; z_in = z; tick; flag_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0); chk("R1 load", pc_load, 0);
    chk("R1 c", c_out, 0); chk("R1 z", z_out, 0); chk("R1 pend", irq_pend, 0);
  endtask

  task automatic t_nested;
    set_flags(1, 0);
    chk("R2 normal c", c_out, 1); chk("R2 normal z", z_out, 0);
    irq_set = 4'b0110; tick; irq_set = 0;
    chk("R3 latched", irq_pend, 4'b0110);
    #1 chk("R3 no boundary", pc_load, 0);
    boundary = 1; gie = 0; pc_in = 12'h123; #1;
    chk("R4 gie low blocks", pc_load, 0);
    gie = 1; #1;
    chk("R4 load", pc_load, 1); chk("R4 vector line1", pc_next, 12'hFF2);
    tick;
    chk("R4 mode int", mode, 1); chk("R4 latch cleared", irq_pend, 4'b0100);
    chk("R4 blocked in int", pc_load, 0);
    boundary = 0;
    chk("R2 int bank c", c_out, 0); chk("R2 int bank z", z_out, 0);
    set_flags(0, 1);
    nmi_set = 1; tick; nmi_set = 0;
    chk("R3 nmi waits boundary", pc_load, 0);
    boundary = 1; gie = 0; pc_in = 12'h456; #1;
    chk("R5 nmi load", pc_load, 1); chk("R5 nmi vector", pc_next, 12'hFFC);
    tick; boundary = 0;
    chk("R5 mode nmi", mode, 2);
    chk("R2 nmi bank c", c_out, 0); chk("R2 nmi bank z", z_out, 0);
    boundary = 1; reti = 1; gie = 1; #1;
    chk("R6 pop nmi", pc_next, 12'h456); chk("R6 pop load", pc_load, 1);
    tick;
    chk("R7 back to int", mode, 1);
    chk("R7 int flags c", c_out, 0); chk("R7 int flags z", z_out, 1);
    chk("R8 reti beats pending", pc_next, 12'h123);
    tick;
    chk("R7 back to normal", mode, 0);
    chk("R7 normal flags c", c_out, 1); chk("R7 normal flags z", z_out, 0);
    reti = 0; boundary = 0;
  endtask

  task automatic t_normal_reti;
    gie = 1; boundary = 1; reti = 1; pc_in = 12'h789; #1;
    chk("R8 reti ignored, irq taken", pc_next, 12'hFF4);
    tick; reti = 0;
    chk("R8 entered int", mode, 1);
    pc_in = 12'h111; reti = 1; #1;
    chk("R8 no earlier pop", pc_next, 12'h789);
    tick; reti = 0; boundary = 0;
    chk("R8 normal again", mode, 0);
  endtask

  task automatic t_priority;
    irq_set = 4'b0001; nmi_set = 1; tick; irq_set = 0; nmi_set = 0;
    boundary = 1; gie = 1; pc_in = 12'h2A0; #1;
    chk("R5 nmi beats maskable", pc_next, 12'hFFC);
    tick; chk("R5 mode", mode, 2);
    reti = 1; #1; chk("R6 pop", pc_next, 12'h2A0);
    tick; reti = 0;
    chk("R7 nmi returns to saved normal", mode, 0);
    pc_in = 12'h2B0; #1;
    chk("R4 line0 vector", pc_next, 12'hFF0);
    tick; boundary = 0;
    chk("R4 mode int", mode, 1); chk("R4 all clear", irq_pend, 0);
  endtask

  initial begin
    tick; tick; rst_n = 1; tick;
    t_reset;
    t_nested;
    t_normal_reti;
    t_priority;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule